// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a new command arrives with the load/advance control low, the full external address is captured as the burst's starting point. Each following cycle with the control high is a continue-burst cycle. The external address is then ignored and the burst moves to its next beat, whether the burst is a read or a write. Only the two lowest address bits change from beat to beat. The upper bits keep the value that was loaded.

Two beat orders are available, picked by a mode input that is normally strapped. In interleaved order (mode high) the low bits are the starting low bits XOR a beat count running 0, 1, 2, 3. In linear order (mode low) they are the starting low bits plus the beat count, modulo four. Either way the address returns to its starting value after every fourth beat. An active-low clock enable stalls the whole sequencer: while it is high, nothing changes.

The beat count is held in a four-state machine with the states BEAT_0, BEAT_1, BEAT_2 and BEAT_3. Reset puts it in BEAT_0. A load cycle moves it from any state to BEAT_0. A step cycle moves it BEAT_0 to BEAT_1, BEAT_1 to BEAT_2, BEAT_2 to BEAT_3, and BEAT_3 back to BEAT_0. A hold cycle (clock enable high) keeps the current state.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `burst_addr` is zero. The stored start address is zero and the beat count is zero.
- R2: On a rising edge with `clk_en_n` low and `load_n` low, `ext_addr` is captured and the beat count is set to zero. From the next cycle on, `burst_addr` equals the captured value. This holds in any state, including in the middle of a burst.
- R3: During a burst, bits `[ADDR_W-1:2]` of `burst_addr` equal those bits of the last loaded address.
- R4: On a step cycle (`clk_en_n` low, `load_n` high), the value of `ext_addr` has no effect on `burst_addr`.
- R5: With `order_sel` = 1 (interleaved), `burst_addr[1:0]` equals the start low bits XOR the beat count.
- R6: With `order_sel` = 0 (linear), `burst_addr[1:0]` equals the start low bits plus the beat count, modulo 4.
- R7: The beat count advances by one on each step cycle and wraps from 3 to 0. After four steps, `burst_addr` equals the loaded address again.
- R8: While `clk_en_n` is high, the beat count and the start address hold. Both load and step requests are ignored.
- R9: Asserting `rst_n` low in the middle of a burst clears the sequence. The next step then yields beat 1 from a zero start address.
- R10: `order_sel` is applied to the stored start and beat without a register. Changing it in the middle of a burst re-maps the current beat at once, and the beat count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the sequencer |
| load_n | input | 1 | Low: load a new start address; high: step to the next beat |
| ext_addr | input | ADDR_W | External address sampled on load cycles |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| burst_addr | output | ADDR_W | Address of the current burst beat |

## Verification
The bench loads starting addresses with every low-bit value that shows the two orders apart. It then steps each burst through the wrap back to its start. A counter that treats both orders alike, or that wraps after the wrong number of beats, fails at the second or fifth beat. On step cycles the bench drives unrelated values on `ext_addr` and holds the enable high while load requests are pending. A design that samples the address or leaks the load past the stall shows a wrong `burst_addr`. The bench also flips `order_sel` in the middle of a burst, resets in the middle of a burst, and reloads in BEAT_3. These catch a registered mode, a reset that misses the start register, and a load that does not take priority over wrap.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [BEAT_W-1:0] {
        BEAT_0 = 2'd0,
        BEAT_1 = 2'd1,
        BEAT_2 = 2'd2,
        BEAT_3 = 2'd3
    } beat_t;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } cmd_t;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic clk_en_n,
    input  logic load_n,
    output cmd_t cmd
);

    always_comb begin
        if (clk_en_n)
            cmd = CMD_HOLD;
        else if (!load_n)
            cmd = CMD_LOAD;
        else
            cmd = CMD_STEP;
    end

endmodule

// File: rtl/burst_phase_fsm.sv
module burst_phase_fsm
    import burst_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cmd_t  cmd,
    output beat_t beat
);

    beat_t state_q;
    beat_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BEAT_0;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_HOLD: state_d = state_q;
            CMD_LOAD: state_d = BEAT_0;
            CMD_STEP: begin
                unique case (state_q)
                    BEAT_0: state_d = BEAT_1;
                    BEAT_1: state_d = BEAT_2;
                    BEAT_2: state_d = BEAT_3;
                    BEAT_3: state_d = BEAT_0;
                    default: state_d = BEAT_0;
                endcase
            end
            default: state_d = state_q;
        endcase
    end

    assign beat = state_q;

endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] start_addr
);

    logic [ADDR_W-1:0] start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            start_q <= '0;
        else if (cmd == CMD_LOAD)
            start_q <= ext_addr;
    end

    assign start_addr = start_q;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              [ADDR_W-1:0] start_addr,
    input  beat_t                          beat,
    input  logic                           order_sel,
    output logic              [ADDR_W-1:0] addr
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] start_lo;
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;
    logic [BEAT_W-1:0] sel_lo;

    assign start_lo = start_addr[BEAT_W-1:0];
    assign lin_lo   = start_lo + BEAT_W'(beat);

    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_lo[i] = start_lo[i] ^ beat[i];
    end

    always_comb begin
        if (order_sel)
            sel_lo = ilv_lo;
        else
            sel_lo = lin_lo;
    end

    assign addr = {start_addr[ADDR_W-1 -: UPPER_W], sel_lo};

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] burst_addr
);

    cmd_t              cmd;
    beat_t             beat_q;
    logic [ADDR_W-1:0] start_q;

    burst_cmd_decode u_dec (
        .clk_en_n (clk_en_n),
        .load_n   (load_n),
        .cmd      (cmd)
    );

    burst_phase_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .beat  (beat_q)
    );

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .ext_addr   (ext_addr),
        .start_addr (start_q)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) u_map (
        .start_addr (start_q),
        .beat       (beat_q),
        .order_sel  (order_sel),
        .addr       (burst_addr)
    );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              load_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              order_sel,
    input logic [ADDR_W-1:0] burst_addr,
    input logic [1:0]        beat
);

    logic [1:0] low;
    assign low = burst_addr[1:0];

    AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n) |=> burst_addr == $past(ext_addr)); // R2

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n) |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2])); // R3

    AST_INTERLEAVED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && order_sel) |=>
            (!order_sel || low == ($past(low) ^ ($past(beat[0]) ? 2'b11 : 2'b01)))); // R5

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && !order_sel) |=> (order_sel || low == $past(low) + 2'd1)); // R6

    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && beat == 2'd3) |=> beat == 2'd0); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> (beat == $past(beat) && (!$stable(order_sel) || $stable(burst_addr)))); // R8

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .load_n     (load_n),
    .ext_addr   (ext_addr),
    .order_sel  (order_sel),
    .burst_addr (burst_addr),
    .beat       (beat_q)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b1;
    logic          load_n = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          order_sel = 1'b1;
    logic [AW-1:0] burst_addr;

    int n_checks = 0;
    int n_errors = 0;

    logic [AW-1:0] m_start = '0;
    int            m_beat = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en_n   (clk_en_n),
        .load_n     (load_n),
        .ext_addr   (ext_addr),
        .order_sel  (order_sel),
        .burst_addr (burst_addr)
    );

    // reference model: start address plus a beat count
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_start <= '0;
            m_beat  <= 0;
        end else if (!clk_en_n) begin
            if (!load_n) begin
                m_start <= ext_addr;
                m_beat  <= 0;
            end else begin
                m_beat  <= (m_beat + 1) % 4;
            end
        end
    end

    function automatic logic [AW-1:0] expected();
        int lo;
        int res;
        lo = int'(m_start[1:0]);
        if (order_sel == 1'b0)
            res = (lo + m_beat) % 4;
        else
            res = lo ^ m_beat;
        return {m_start[AW-1:2], 2'(res)};
    endfunction

    task automatic check(input string tag);
        logic [AW-1:0] exp;
        exp = expected();
        n_checks++;
        if (burst_addr !== exp) begin
            n_errors++;
            $display("FAIL %s: burst_addr=%h expected %h", tag, burst_addr, exp);
        end
    endtask

    task automatic step(input logic en_n, input logic ld_n, input logic [AW-1:0] a,
                        input logic mode, input string tag);
        clk_en_n  = en_n;
        load_n    = ld_n;
        ext_addr  = a;
        order_sel = mode;
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(tag);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset("R1");

        // interleaved burst from low bits 2, ext_addr noise on steps
        step(1'b0, 1'b0, 16'h1232, 1'b1, "R2");
        step(1'b0, 1'b1, 16'hFFFF, 1'b1, "R4");
        step(1'b0, 1'b1, 16'h0000, 1'b1, "R5");
        step(1'b0, 1'b1, 16'hABCD, 1'b1, "R3");
        step(1'b0, 1'b1, 16'h5555, 1'b1, "R7");

        // interleaved from low bits 1 and 3
        step(1'b0, 1'b0, 16'h8001, 1'b1, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 16'h7FFE, 1'b1, "R5");
        step(1'b0, 1'b0, 16'hC0DB, 1'b1, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 16'h0000, 1'b1, "R5");

        // linear bursts
        step(1'b0, 1'b0, 16'h00A7, 1'b0, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 16'h1111, 1'b0, "R6");
        step(1'b0, 1'b1, 16'h2222, 1'b0, "R7");
        step(1'b0, 1'b0, 16'h3C01, 1'b0, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 16'hFFFC, 1'b0, "R6");

        // stalls with pending load and step
        step(1'b0, 1'b0, 16'h5A51, 1'b1, "R2");
        step(1'b0, 1'b1, 16'h0000, 1'b1, "R5");
        step(1'b1, 1'b0, 16'h0003, 1'b1, "R8");
        step(1'b1, 1'b0, 16'hFFFF, 1'b1, "R8");
        step(1'b1, 1'b1, 16'h1234, 1'b1, "R8");
        step(1'b0, 1'b1, 16'h0000, 1'b1, "R5");

        // order change mid-burst, while stalled
        step(1'b1, 1'b1, 16'h0000, 1'b0, "R10");
        step(1'b1, 1'b1, 16'h0000, 1'b1, "R10");
        step(1'b0, 1'b1, 16'h0000, 1'b0, "R10");

        // reload in the last beat
        step(1'b0, 1'b0, 16'h4442, 1'b1, "R2");
        step(1'b0, 1'b1, 16'h0000, 1'b1, "R5");

        // reset mid-burst
        step(1'b0, 1'b1, 16'h0000, 1'b1, "R5");
        clk_en_n = 1'b1;
        do_reset("R9");
        step(1'b0, 1'b1, 16'hFFFF, 1'b1, "R9");
        step(1'b0, 1'b1, 16'hFFFF, 1'b1, "R9");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule